// File: doc/BRIEF.md
# Per-Flow Stateful Port-Knock Filter

This block decides, for each packet, whether it is dropped or forwarded, based on a small state that it keeps for every source address. A source unlocks a guarded destination port by first sending packets to a configured series of knock ports in the right order. Each packet is handled in three steps in the same cycle:

1. The block looks up the state of its source address in an on-chip key-to-state store.
2. It applies one transition table, shared by every flow, to that state and the packet's destination port.
3. It writes the resulting state back to the store.

No controller takes part in this loop.

A flow advances one step for each correct knock, and every knock packet is dropped. Once the last knock is seen, the flow is open. In the open state, packets to the guarded port are forwarded and all other packets are dropped. A wrong port in the middle of the series sends the flow back to the idle state. An idle flow holds no store entry. The knock ports and the guarded port are held in registers written through a small configuration port. These registers reset to knock ports 5123, 6234, 7345, 8456 and guarded port 22.

Top module: `knock_filter`

## Requirements
- R1: After a synchronous active-low reset, `dec_valid` and `dec_fwd` are 0, the state store is empty, the knock ports are 5123, 6234, 7345, 8456 in that order, and the guarded port is 22.
- R2: For a packet presented with `pkt_valid` high, `dec_valid` is high in the next cycle and carries that packet's decision. In a cycle after `pkt_valid` was low, `dec_valid` and `dec_fwd` are 0.
- R3: A flow in knock step k (idle is step 0) that sends a packet to knock port k moves to step k+1. The packet is dropped (`dec_fwd`=0). After the last knock the flow is open.
- R4: A packet to any port other than the expected knock port returns a flow in step 1 to 3 to idle and frees its entry. An idle flow with a wrong port stays idle and takes no entry. Both packets are dropped.
- R5: In the open state, a packet to the guarded port is forwarded (`dec_fwd`=1), and a packet to any other port is dropped. In both cases the flow stays open.
- R6: A source address with no entry in the store is treated as idle.
- R7: A packet presented in the cycle right after a packet of the same source sees the state written by that earlier packet.
- R8: The store holds 16 flows, and no source address ever occupies two entries. A non-idle result for an absent source is written to the entry at a round-robin pointer, whatever that entry holds. The pointer starts at 0 and advances by one, with wrap, on each such allocation. An evicted flow is treated as idle afterwards.
- R9: A write with `cfg_we`=1 sets knock port `cfg_sel` (0 to 3) or the guarded port (`cfg_sel`=4) to `cfg_data`. The new value applies to packets from the next cycle on. A packet in the same cycle uses the old value. `cfg_sel` values 5 to 7 change nothing.
- R10: All flows share one transition table, but each source advances independently of the others, even when their packets are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_src | input | 32 | Source IPv4 address, used as the flow key |
| pkt_dport | input | 16 | Destination L4 port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0-3 knock ports in order, 4 guarded port |
| cfg_data | input | 16 | Port value to write |
| dec_valid | output | 1 | Decision valid, one cycle after the packet |
| dec_fwd | output | 1 | 1 = forward, 0 = drop |

## Verification
Two pairs of functions can fall in the same cycle.

- **Write-back and lookup.** The write-back of one packet and the lookup of the next packet from the same source share a cycle. Back-to-back bursts of one source's knocks, and interleaved bursts of two sources, provoke this case.
- **Configuration write and packet.** A configuration write and a packet that depends on the register being written share a cycle. A knock sent in the very cycle its port is rewritten provokes this case.

A behavioural reference model in the bench applies each packet with the configuration that was in force before the write, and applies the write afterwards. The outputs are compared against this model on every clock. Eviction by a seventeenth flow is judged by whether the evicted source can still open the guarded port.

// File: rtl/knk_pkg.sv
// Package: shared constants for the port-knock filter.
// Assumes 16-bit L4 ports; reset values for knock and guarded ports.
package knk_pkg;
    localparam int PORT_W = 16;
    localparam logic [PORT_W-1:0] GUARD_RESET = 16'd22;

    // Reset value of knock port number idx in the series.
    function automatic logic [PORT_W-1:0] knock_reset(input int idx);
        case (idx)
            0:       return 16'd5123;
            1:       return 16'd6234;
            2:       return 16'd7345;
            3:       return 16'd8456;
            default: return 16'd0;
        endcase
    endfunction
endpackage

// File: rtl/knk_cfg_regs.sv
// Module: knock-port and guarded-port registers.
// Assumes writes with an out-of-range select are ignored; values
// change at the clock edge, so same-cycle users see the old value.
module knk_cfg_regs
    import knk_pkg::*;
#(
    parameter int KNOCKS = 4,
    localparam int SEL_W = $clog2(KNOCKS + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [PORT_W-1:0]              cfg_data,
    output logic [KNOCKS-1:0][PORT_W-1:0]  knock_ports,
    output logic [PORT_W-1:0]              guard_port
);
    genvar k;
    generate
        for (k = 0; k < KNOCKS; k++) begin : g_knock
            // Holds knock port k of the series.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    knock_ports[k] <= knock_reset(k);
                else if (cfg_we && cfg_sel == SEL_W'(k))
                    knock_ports[k] <= cfg_data;
            end
        end
    endgenerate

    // Holds the guarded port opened by a completed series.
    always_ff @(posedge clk) begin
        if (!rst_n)
            guard_port <= GUARD_RESET;
        else if (cfg_we && cfg_sel == SEL_W'(KNOCKS))
            guard_port <= cfg_data;
    end
endmodule

// File: rtl/knk_xfsm.sv
// Module: shared transition table indexed by state and destination port.
// States: 0 = idle, 1..KNOCKS-1 = knock steps, KNOCKS = open.
// Assumes a purely combinational lookup; every knock packet drops.
module knk_xfsm
    import knk_pkg::*;
#(
    parameter int KNOCKS = 4,
    localparam int ST_W = $clog2(KNOCKS + 1)
) (
    input  logic [ST_W-1:0]                cur_state,
    input  logic [PORT_W-1:0]              dport,
    input  logic [KNOCKS-1:0][PORT_W-1:0]  knock_ports,
    input  logic [PORT_W-1:0]              guard_port,
    output logic [ST_W-1:0]                nxt_state,
    output logic                           fwd
);
    // Maps (state, port) to next state and forward decision.
    always_comb begin
        nxt_state = '0;
        fwd       = 1'b0;
        if (cur_state == ST_W'(KNOCKS)) begin
            nxt_state = ST_W'(KNOCKS);
            fwd       = (dport == guard_port);
        end else begin
            for (int k = 0; k < KNOCKS; k++) begin
                if (cur_state == ST_W'(k) && dport == knock_ports[k])
                    nxt_state = ST_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/knk_state_store.sv
// Module: per-flow key-to-state store with round-robin allocation.
// Assumes lookup and write-back use the same key in the same cycle;
// writing state 0 frees a hit entry, a miss with state 0 does nothing.
module knk_state_store #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 32,
    parameter int ST_W    = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KEY_W-1:0]   lk_key,
    input  logic               wr_en,
    input  logic [ST_W-1:0]    wr_state,
    output logic [ST_W-1:0]    lk_state,
    output logic [ENTRIES-1:0] hit_vec
);
    logic [ENTRIES-1:0] vld;
    logic [KEY_W-1:0]   keys [ENTRIES];
    logic [ST_W-1:0]    sts  [ENTRIES];
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   hit_idx;
    logic               hit;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = vld[g] && (keys[g] == lk_key);
        end
    endgenerate

    // Selects the matching entry's state; a miss reads as idle.
    always_comb begin
        hit      = |hit_vec;
        hit_idx  = '0;
        lk_state = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx  = IDX_W'(i);
                lk_state = sts[i];
            end
        end
    end

    // Writes back the new state: update, free or allocate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= '0;
            rr_ptr <= '0;
        end else if (wr_en) begin
            if (wr_state == '0) begin
                if (hit) vld[hit_idx] <= 1'b0;
            end else if (hit) begin
                sts[hit_idx] <= wr_state;
            end else begin
                keys[rr_ptr] <= lk_key;
                sts[rr_ptr]  <= wr_state;
                vld[rr_ptr]  <= 1'b1;
                rr_ptr       <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/knock_filter.sv
// Module: top of the per-flow port-knock filter.
// Lookup, transition and write-back happen in one cycle, so a packet
// of the same flow in the next cycle sees the new state. The decision
// is registered: one cycle of latency.
module knock_filter
    import knk_pkg::*;
#(
    parameter int KNOCKS  = 4,
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 32,
    localparam int SEL_W  = $clog2(KNOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [KEY_W-1:0]  pkt_src,
    input  logic [PORT_W-1:0] pkt_dport,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [PORT_W-1:0] cfg_data,
    output logic              dec_valid,
    output logic              dec_fwd
);
    localparam int ST_W = $clog2(KNOCKS + 1);

    logic [KNOCKS-1:0][PORT_W-1:0] knock_ports;
    logic [PORT_W-1:0]             guard_port;
    logic [ST_W-1:0]               cur_state;
    logic [ST_W-1:0]               nxt_state;
    logic                          x_fwd;
    logic [ENTRIES-1:0]            hit_vec;

    knk_cfg_regs #(.KNOCKS(KNOCKS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .knock_ports(knock_ports), .guard_port(guard_port)
    );

    knk_state_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .ST_W(ST_W)) u_store (
        .clk(clk), .rst_n(rst_n), .lk_key(pkt_src), .wr_en(pkt_valid),
        .wr_state(nxt_state), .lk_state(cur_state), .hit_vec(hit_vec)
    );

    knk_xfsm #(.KNOCKS(KNOCKS)) u_xfsm (
        .cur_state(cur_state), .dport(pkt_dport), .knock_ports(knock_ports),
        .guard_port(guard_port), .nxt_state(nxt_state), .fwd(x_fwd)
    );

    // Registers the per-packet decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_fwd   <= 1'b0;
        end else begin
            dec_valid <= pkt_valid;
            dec_fwd   <= pkt_valid && x_fwd;
        end
    end
endmodule

// File: rtl/knk_filter_chk.sv
// Checker: temporal properties of the port-knock filter, bound to the top.
module knk_filter_chk #(
    parameter int KNOCKS  = 4,
    parameter int ENTRIES = 16,
    localparam int ST_W   = $clog2(KNOCKS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pkt_valid,
    input logic [15:0]        pkt_dport,
    input logic [15:0]        guard_port,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ST_W-1:0]    x_cur,
    input logic [ST_W-1:0]    x_nxt,
    input logic               dec_valid,
    input logic               dec_fwd
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!dec_valid && !dec_fwd));

    // R2
    dec_follows_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> dec_valid);

    // R2
    idle_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> (!dec_valid && !dec_fwd));

    // R5
    fwd_only_open_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fwd |-> (dec_valid && $past(x_cur) == ST_W'(KNOCKS)
                     && $past(pkt_dport) == $past(guard_port)));

    // R5
    open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && x_cur == ST_W'(KNOCKS)) |-> x_nxt == ST_W'(KNOCKS));

    // R8
    single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

bind knock_filter knk_filter_chk #(.KNOCKS(KNOCKS), .ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_dport(pkt_dport),
    .guard_port(guard_port), .hit_vec(hit_vec), .x_cur(cur_state),
    .x_nxt(nxt_state), .dec_valid(dec_valid), .dec_fwd(dec_fwd)
);

// File: tb/knock_filter_tb.sv
// Bench: behavioural reference model compared on every clock.
module knock_filter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [31:0] pkt_src = '0;
    logic [15:0] pkt_dport = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        dec_valid;
    logic        dec_fwd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    logic [31:0] m_key [16];
    int          m_st  [16];
    bit          m_vld [16];
    int          m_rr;
    logic [15:0] m_kp  [4];
    logic [15:0] m_guard;

    bit    exp_v = 0;
    bit    exp_f = 0;
    string exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    knock_filter u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_src(pkt_src),
        .pkt_dport(pkt_dport), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .dec_valid(dec_valid), .dec_fwd(dec_fwd)
    );

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_st[i] = 0; m_key[i] = '0; end
        m_rr = 0;
        m_kp[0] = 16'd5123; m_kp[1] = 16'd6234; m_kp[2] = 16'd7345; m_kp[3] = 16'd8456;
        m_guard = 16'd22;
    endtask

    // Applies one packet to the model; returns the forward decision.
    function automatic bit model_pkt(logic [31:0] s, logic [15:0] p);
        int hi = -1;
        int st = 0;
        int nx;
        bit f = 0;
        for (int i = 0; i < 16; i++) if (m_vld[i] && m_key[i] == s) hi = i;
        if (hi >= 0) st = m_st[hi];
        if (st == 4) begin
            nx = 4;
            f = (p == m_guard);
        end else begin
            nx = (p == m_kp[st]) ? st + 1 : 0;
        end
        if (nx == 0) begin
            if (hi >= 0) m_vld[hi] = 0;
        end else if (hi >= 0) begin
            m_st[hi] = nx;
        end else begin
            m_key[m_rr] = s; m_st[m_rr] = nx; m_vld[m_rr] = 1;
            m_rr = (m_rr + 1) % 16;
        end
        return f;
    endfunction

    task automatic compare();
        checks++;
        if (dec_valid !== exp_v) begin
            fails++;
            $display("FAIL %s: dec_valid got %0b expected %0b", exp_tag, dec_valid, exp_v);
        end
        checks++;
        if (dec_fwd !== exp_f) begin
            fails++;
            $display("FAIL %s: dec_fwd got %0b expected %0b", exp_tag, dec_fwd, exp_f);
        end
    endtask

    // One clock: compare outputs for the previous cycle, then drive new inputs.
    task automatic step(bit v, logic [31:0] s, logic [15:0] p,
                        bit we, logic [2:0] sel, logic [15:0] d, string tag);
        @(negedge clk);
        compare();
        if (v) begin
            exp_v = 1; exp_f = model_pkt(s, p);
        end else begin
            exp_v = 0; exp_f = 0;
        end
        exp_tag = tag;
        if (we) begin
            if (sel < 4) m_kp[sel] = d;
            else if (sel == 4) m_guard = d;
        end
        pkt_valid = v; pkt_src = s; pkt_dport = p;
        cfg_we = we; cfg_sel = sel; cfg_data = d;
    endtask

    task automatic pkt(logic [31:0] s, logic [15:0] p, string tag);
        step(1, s, p, 0, 3'd0, 16'd0, tag);
    endtask

    task automatic idle(string tag);
        step(0, 32'd0, 16'd0, 0, 3'd0, 16'd0, tag);
    endtask

    task automatic full_knock(logic [31:0] s, string tag);
        pkt(s, 16'd5123, tag); pkt(s, 16'd6234, tag);
        pkt(s, 16'd7345, tag); pkt(s, 16'd8456, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] plist [6];
        model_reset();
        plist[0] = 16'd5123; plist[1] = 16'd6234; plist[2] = 16'd7345;
        plist[3] = 16'd8456; plist[4] = 16'd22;   plist[5] = 16'd80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(); // R1 outputs quiet during reset
        rst_n = 1'b1;

        // R1 R6 default ports after reset, unknown source starts idle
        idle("R1");
        full_knock(32'h0102_0304, "R3");
        pkt(32'h0102_0304, 16'd22, "R5");
        pkt(32'h0102_0304, 16'd80, "R5");
        pkt(32'h0102_0304, 16'd22, "R5");
        idle("R2");
        pkt(32'h0A00_0001, 16'd22, "R6");

        // R4 wrong port mid-series returns to idle
        pkt(32'h0A00_0002, 16'd5123, "R4");
        pkt(32'h0A00_0002, 16'd6234, "R4");
        pkt(32'h0A00_0002, 16'd9999, "R4");
        pkt(32'h0A00_0002, 16'd7345, "R4");
        pkt(32'h0A00_0002, 16'd8456, "R4");
        pkt(32'h0A00_0002, 16'd22, "R4");
        pkt(32'h0A00_0002, 16'd6234, "R4"); // idle with wrong port
        full_knock(32'h0A00_0002, "R4");
        pkt(32'h0A00_0002, 16'd22, "R4");

        // R7 R10 interleaved back-to-back flows with a gap variant
        pkt(32'h0B00_0001, 16'd5123, "R10");
        pkt(32'h0B00_0002, 16'd5123, "R10");
        pkt(32'h0B00_0001, 16'd6234, "R7");
        pkt(32'h0B00_0001, 16'd7345, "R7");
        pkt(32'h0B00_0002, 16'd6234, "R10");
        idle("R2");
        pkt(32'h0B00_0001, 16'd8456, "R7");
        pkt(32'h0B00_0001, 16'd22, "R7");
        pkt(32'h0B00_0002, 16'd22, "R10");

        // R9 config write in the same cycle as a dependent packet
        step(1, 32'h0C00_0001, 16'd5123, 1, 3'd0, 16'd100, "R9");
        pkt(32'h0C00_0001, 16'd6234, "R9");
        step(0, 32'd0, 16'd0, 1, 3'd7, 16'd999, "R9"); // ignored select
        pkt(32'h0C00_0002, 16'd100, "R9");
        pkt(32'h0C00_0002, 16'd6234, "R9");
        pkt(32'h0C00_0002, 16'd7345, "R9");
        pkt(32'h0C00_0002, 16'd8456, "R9");
        pkt(32'h0C00_0002, 16'd22, "R9");
        step(0, 32'd0, 16'd0, 1, 3'd4, 16'd443, "R9");
        pkt(32'h0C00_0002, 16'd22, "R9");
        pkt(32'h0C00_0002, 16'd443, "R9");
        step(0, 32'd0, 16'd0, 1, 3'd0, 16'd5123, "R9");
        step(0, 32'd0, 16'd0, 1, 3'd4, 16'd22, "R9");

        // R8 eviction by sixteen newer allocations
        pkt(32'h0D00_0000, 16'd5123, "R8");
        for (int i = 1; i <= 16; i++) pkt(32'h0D00_0000 + i, 16'd5123, "R8");
        pkt(32'h0D00_0000, 16'd6234, "R8");
        pkt(32'h0D00_0000, 16'd7345, "R8");
        pkt(32'h0D00_0000, 16'd8456, "R8");
        pkt(32'h0D00_0000, 16'd22, "R8");

        // R10 random mixed traffic from a few sources
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 4) == 0) idle("R2");
            else pkt(32'h0E00_0000 + $urandom_range(0, 2),
                     plist[$urandom_range(0, 5)], "R10");
        end
        idle("R2");
        idle("R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule